// File: doc/BRIEF.md
# Register-Programmed Power-of-Two Clock Divider

This block derives gated, divided clocks from a fast reference clock. It contains a parameterised number of identical divider channels. Each channel sits at its own base address, and the bases are spaced a fixed stride apart. A byte-wide write and read port reaches every channel. A channel holds two registers: a ratio register, whose low three bits choose a power-of-two division ratio, and a control register, which carries the run request and a live status bit.

All logic runs on `clk`, and `clk` is twice the nominal reference rate. One reference period is two `clk` cycles, so every output edge comes straight from a flop. A division ratio R gives an output that is high for R `clk` cycles and low for R `clk` cycles. The run request passes through a two-stage synchroniser. The output gate changes state only while the divided phase is low. When the ratio changes during running, the new ratio is loaded only at the end of a high phase. As a result, the output never carries a truncated pulse.

The expected use is a fixed sequence: clear the run bit, write the new ratio code, then set the run bit again. Each change of the run bit takes effect within a bounded time that depends on the ratio.

Top module: `clkdiv_bank`

## Requirements
- R1: After a synchronous reset, each channel's ratio register reads 0x01 and its control register reads 0x00, and every output is low.
- R2: The ratio register sits at offset 0x43 from a channel's base. All eight bits read back as written. Only bits [2:0] (the code) affect the division.
- R3: The control register sits at offset 0x46. Bit 7 is the run request and reads back as written. Bit 0 reads 1 only while the channel's output gate is open. All other bits are ignored on write and read as 0.
- R4: A code N from 1 to 7 gives ratio R = 2^(N-1). While running, each output period is R high `clk` cycles followed by R low `clk` cycles.
- R5: Code 0 behaves exactly like code 1, which is ratio 1.
- R6: After the run bit is set, the output's first rising edge comes within 2*(2+3R) `clk` cycles of the write, and status bit 0 then reads 1.
- R7: After the run bit is cleared, the output is low and stays low within 2*(2+3R) `clk` cycles, and status bit 0 reads 0.
- R8: Every high pulse on an output lasts exactly one full ratio of 1, 2, 4, 8, 16, 32 or 64 cycles. This holds across the stop, re-program and start sequence. The gate changes only while the divided phase is low.
- R9: A ratio written while the output runs takes effect at the end of the current high phase. Later periods use the new ratio.
- R10: Channel i is decoded at base i*0x100. Channels are independent. Accesses to addresses that match no register read 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock, twice the nominal reference rate |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| div_clk_o | output | NUM_INST | Gated divided clock, one bit per channel |

## Verification
The assertions assume that `rst` is synchronous and is held for at least one edge before any write. They also assume that `bus_we` and the address change only between rising edges. The bench drives every bus signal on the falling edge and samples outputs there, so each write lands on exactly one rising edge. A ratio written during running is only guaranteed glitch-free because of the boundary load. The stimulus therefore includes one write taken without a stop, alongside the stop, re-program and start sequence applied for every code.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int CODE_W   = 3;
    localparam int HALF_W   = (1 << CODE_W) - 2;
    localparam int DATA_W   = 8;
    localparam logic [7:0] OFF_RATIO = 8'h43;
    localparam logic [7:0] OFF_CTRL  = 8'h46;
    localparam int RUN_BIT  = 7;
    localparam int STAT_BIT = 0;
    localparam logic [DATA_W-1:0] RATIO_RST = 8'h01;

    // code -> (ratio - 1); codes 0 and 1 both mean ratio 1
    function automatic logic [HALF_W-1:0] code_to_half(input logic [CODE_W-1:0] code);
        logic [HALF_W:0] ratio;
        if (code <= CODE_W'(1))
            ratio = (HALF_W+1)'(1);
        else
            ratio = (HALF_W+1)'(1) << (code - CODE_W'(1));
        return HALF_W'(ratio - (HALF_W+1)'(1));
    endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BASE   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              running,
    output logic [CODE_W-1:0] code_o,
    output logic              run_req_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] A_RATIO = ADDR_W'(BASE + int'(OFF_RATIO));
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(BASE + int'(OFF_CTRL));

    typedef struct packed {
        logic [DATA_W-1:0] ratio;
        logic              run;
    } reg_t;

    reg_t st_d, st_q;
    logic hit_ratio, hit_ctrl;

    assign hit_ratio = (addr == A_RATIO);
    assign hit_ctrl  = (addr == A_CTRL);

    always_comb begin
        st_d = st_q;
        if (we && hit_ratio) st_d.ratio = wdata;
        if (we && hit_ctrl)  st_d.run   = wdata[RUN_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ratio <= RATIO_RST;
            st_q.run   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit_ratio) begin
            rdata_o = st_q.ratio;
        end else if (hit_ctrl) begin
            rdata_o[RUN_BIT]  = st_q.run;
            rdata_o[STAT_BIT] = running;
        end
    end

    assign code_o    = st_q.ratio[CODE_W-1:0];
    assign run_req_o = st_q.run;
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_req_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              div_clk_o,
    output logic              run_o,
    output logic              phase_o,
    output logic [HALF_W-1:0] half_o
);
    typedef struct packed {
        logic              sync1;
        logic              sync2;
        logic              run;
        logic              phase;
        logic              out;
        logic [HALF_W-1:0] cnt;
        logic [HALF_W-1:0] half;
    } core_t;

    core_t st_d, st_q;
    logic [HALF_W-1:0] target;

    assign target = code_to_half(code_i);

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = run_req_i;
        st_d.sync2 = st_q.sync1;
        // half-period counter; ratio reload at end of a high phase
        if (st_q.cnt == st_q.half) begin
            st_d.cnt   = '0;
            st_d.phase = ~st_q.phase;
            if (st_q.phase) st_d.half = target;
        end else begin
            st_d.cnt = st_q.cnt + HALF_W'(1);
        end
        // gate moves only while divided phase is low
        if (!st_q.phase) st_d.run = st_q.sync2;
        // stopped: adopt new ratio at once and restart from a low phase
        if (!st_q.run && (target != st_q.half)) begin
            st_d.half  = target;
            st_d.cnt   = '0;
            st_d.phase = 1'b0;
        end
        st_d.out = st_d.run & st_d.phase;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign div_clk_o = st_q.out;
    assign run_o     = st_q.run;
    assign phase_o   = st_q.phase;
    assign half_o    = st_q.half;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int NUM_INST = 2,
    parameter int ADDR_W   = 12,
    parameter int BASE     = 0,
    parameter int STRIDE   = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_we,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_INST-1:0] div_clk_o
);
    logic [NUM_INST-1:0]             run_w;
    logic [NUM_INST-1:0]             phase_w;
    logic [NUM_INST-1:0]             req_w;
    logic [NUM_INST-1:0][HALF_W-1:0] half_w;
    logic [NUM_INST-1:0][CODE_W-1:0] code_w;
    logic [NUM_INST-1:0][DATA_W-1:0] rd_w;

    for (genvar g = 0; g < NUM_INST; g++) begin : g_ch
        clkdiv_regs #(
            .ADDR_W (ADDR_W),
            .BASE   (BASE + g * STRIDE)
        ) u_regs (
            .clk       (clk),
            .rst       (rst),
            .addr      (bus_addr),
            .wdata     (bus_wdata),
            .we        (bus_we),
            .running   (run_w[g]),
            .code_o    (code_w[g]),
            .run_req_o (req_w[g]),
            .rdata_o   (rd_w[g])
        );

        clkdiv_core u_core (
            .clk       (clk),
            .rst       (rst),
            .run_req_i (req_w[g]),
            .code_i    (code_w[g]),
            .div_clk_o (div_clk_o[g]),
            .run_o     (run_w[g]),
            .phase_o   (phase_w[g]),
            .half_o    (half_w[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_INST; i++) bus_rdata = bus_rdata | rd_w[i];
    end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
    parameter int N  = 2,
    parameter int HW = 6
) (
    input logic               clk,
    input logic               rst,
    input logic [N-1:0]       out,
    input logic [N-1:0]       run,
    input logic [N-1:0]       phase,
    input logic [N-1:0][HW-1:0] half
);
    // R1: the cycle after reset, every output is low
    p_reset_quiet_r1: assert property (@(posedge clk) $past(rst) |-> (out == '0));

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R8: an output is high only while its gate is open
        p_out_needs_run_r8: assert property (@(posedge clk) disable iff (rst)
            out[g] |-> run[g]);
        // R8: the gate changes only after a low divided phase
        p_gate_low_phase_r8: assert property (@(posedge clk) disable iff (rst)
            !$stable(run[g]) |-> !$past(phase[g]));
        // R9: ratio in effect never changes inside a high pulse
        p_ratio_hold_high_r9: assert property (@(posedge clk) disable iff (rst)
            (out[g] && $past(out[g])) |-> $stable(half[g]));
        // R7: once the gate is shut the output drops with it
        p_stop_low_r7: assert property (@(posedge clk) disable iff (rst)
            $fell(run[g]) |-> !out[g]);
    end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(
    .N  (NUM_INST),
    .HW (clkdiv_pkg::HALF_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .out   (div_clk_o),
    .run   (run_w),
    .phase (phase_w),
    .half  (half_w)
);

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        we = 1'b0;
    logic [7:0]  rdata;
    logic [1:0]  dout;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    int plen [2];
    bit seen1;

    always #10 clk = ~clk;

    clkdiv_bank #(.NUM_INST(2), .ADDR_W(12), .BASE(0), .STRIDE(256)) dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata),
        .bus_we(we), .bus_rdata(rdata), .div_clk_o(dout)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic measure(input int i, output int hi, output int lo);
        int guard = 0;
        hi = 0; lo = 0;
        @(negedge clk);
        while (dout[i] == 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
        while (dout[i] == 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        while (dout[i] == 1'b1 && guard < 4000) begin hi++; @(negedge clk); guard++; end
        while (dout[i] == 1'b0 && guard < 4000) begin lo++; @(negedge clk); guard++; end
    endtask

    // R8: every completed high pulse is a full power-of-two length
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (rst) begin
                plen[i] = 0;
            end else if (dout[i]) begin
                plen[i] = plen[i] + 1;
                if (i == 1) seen1 = 1'b1;
            end else if (plen[i] != 0) begin
                chk(((plen[i] & (plen[i] - 1)) == 0) && plen[i] <= 64,
                    "R8 pulse length", plen[i], 0);
                plen[i] = 0;
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int hi, lo, lat, r, highs;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(12'h043, d); chk(d == 8'h01, "R1 ratio reg ch0", d, 8'h01);
        rd(12'h143, d); chk(d == 8'h01, "R1 ratio reg ch1", d, 8'h01);
        rd(12'h046, d); chk(d == 8'h00, "R1 ctrl reg ch0", d, 0);
        rd(12'h146, d); chk(d == 8'h00, "R1 ctrl reg ch1", d, 0);
        chk(dout == 2'b00, "R1 outputs low", dout, 0);

        // R2: full byte readback, upper bits ignored (0xF9 -> code 1)
        wr(12'h043, 8'hF9);
        rd(12'h043, d); chk(d == 8'hF9, "R2 readback", d, 8'hF9);
        wr(12'h046, 8'h80);
        measure(0, hi, lo);
        chk(hi == 1 && lo == 1, "R2 upper bits ignored hi", hi, 1);
        // R5: code 0 same as code 1
        wr(12'h043, 8'hF8);
        measure(0, hi, lo); measure(0, hi, lo);
        chk(hi == 1 && lo == 1, "R5 code 0 ratio", hi, 1);
        r = 1;

        // R4/R6/R7: sweep every code with stop, program, start
        seen1 = 1'b0;
        for (int code = 1; code < 8; code++) begin
            wr(12'h046, 8'h00);
            repeat (2 * (2 + 3 * r)) @(negedge clk);
            rd(12'h046, d); chk(d == 8'h00, "R7 status cleared", d, 0);
            highs = 0;
            for (int k = 0; k < 200; k++) begin @(negedge clk); if (dout[0]) highs++; end
            chk(highs == 0, "R7 output stays low", highs, 0);
            wr(12'h043, 8'(code));
            r = 1 << (code - 1);
            wr(12'h046, 8'h80);
            lat = 1;
            while (!dout[0] && lat < 2000) begin @(negedge clk); lat++; end
            chk(lat <= 2 * (2 + 3 * r), "R6 start latency", lat, 2 * (2 + 3 * r));
            rd(12'h046, d); chk(d == 8'h81, "R6 status set", d, 8'h81);
            measure(0, hi, lo);
            chk(hi == r, "R4 high length", hi, r);
            chk(lo == r, "R4 low length", lo, r);
        end
        chk(!seen1, "R10 idle channel untouched", seen1, 0);

        // R9: ratio change without stop (64 -> 2)
        wr(12'h043, 8'h02);
        measure(0, hi, lo); measure(0, hi, lo);
        chk(hi == 2 && lo == 2, "R9 new ratio adopted", hi, 2);

        // R3: ctrl bits other than bit 7 ignored, on idle channel 1
        wr(12'h146, 8'h7F);
        repeat (20) @(negedge clk);
        rd(12'h146, d); chk(d == 8'h00, "R3 other ctrl bits ignored", d, 0);
        chk(dout[1] == 1'b0, "R3 ch1 still off", dout[1], 0);

        // R10: channel 1 at base 0x100
        wr(12'h143, 8'h03);
        rd(12'h143, d); chk(d == 8'h03, "R10 ch1 ratio", d, 3);
        rd(12'h043, d); chk(d == 8'h02, "R10 ch0 ratio unchanged", d, 2);
        wr(12'h146, 8'h80);
        repeat (2 * (2 + 3 * 4)) @(negedge clk);
        rd(12'h146, d); chk(d == 8'h81, "R3 ctrl readback running", d, 8'h81);
        measure(1, hi, lo);
        chk(hi == 4 && lo == 4, "R10 ch1 ratio 4", hi, 4);
        measure(0, hi, lo);
        chk(hi == 2 && lo == 2, "R10 ch0 still ratio 2", hi, 2);

        // R10: unmapped addresses
        wr(12'h044, 8'hFF);
        rd(12'h044, d); chk(d == 8'h00, "R10 unmapped read", d, 0);
        wr(12'h246, 8'h00);
        rd(12'h246, d); chk(d == 8'h00, "R10 out of range read", d, 0);
        rd(12'h043, d); chk(d == 8'h02, "R10 unmapped write no effect", d, 2);
        rd(12'h046, d); chk(d == 8'h81, "R10 ch0 ctrl intact", d, 8'h81);

        // R1: reset while running
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        chk(dout == 2'b00, "R1 outputs low after reset", dout, 0);
        rd(12'h143, d); chk(d == 8'h01, "R1 ratio restored", d, 1);
        rd(12'h046, d); chk(d == 8'h00, "R1 ctrl restored", d, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule